// File: doc/BRIEF.md
# Multi-Dimensional Element Index Remapper

This block sequences the element indices of a vector loop through a one-, two- or three-dimensional array view, without moving data. A 32-bit shape word gives three axis sizes, a nesting order, a per-axis reverse flag and an optional output modulus. Each step strobe turns the current element position into one remapped element index. The same register elements can therefore be read in transposed, reversed, replicated or wrapped order.

Loading a shape word also loads a start element position. The three axis counters are derived from that position under the chosen nesting order, so a loop interrupted part way through resumes exactly where it stopped. A shape word of all zeros switches remapping off, and the block then passes the linear element number straight through.

Top module: `idx_remap_seq`

## Requirements
- R1: After reset `idx_valid` and `cfg_err` are low and `idx` is zero.
- R2: Shape word fields are: x size in bits 5..0, y size in 11..6, z size in 17..12, order select in 20..18, reverse flags in 23..21 (bit 21 x, 22 y, 23 z), modulus in 29..24. A size field holding n means n+1 elements on that axis.
- R3: With an all-zero shape word, `idx` equals the linear element number, which is the start position plus the number of steps taken since the load, modulo 2^POS_W.
- R4: The index is x + y*X + z*X*Y, where X and Y are the decoded element counts of the x and y axes.
- R5: Order select 0..5 gives the axis nesting (fastest first) x-y-z, x-z-y, y-x-z, y-z-x, z-x-y, z-y-x. The fastest axis advances on every step and each axis carries into the next one when it wraps.
- R6: An axis whose reverse flag is set presents size-1 down to 0 in place of 0 up to size-1.
- R7: A nonzero modulus m makes the output index (computed index) mod m. A zero modulus leaves the index unchanged.
- R8: Once all X*Y*Z elements have been presented, the counters return to zero and the sequence repeats.
- R9: A load with start position k makes the next step present element k mod (X*Y*Z) of the sequence, and the steps after it continue from there.
- R10: Order select 6 or 7 raises `cfg_err` from the cycle after the load. While `cfg_err` is high no step produces `idx_valid`.
- R11: Each step with no load in the same cycle produces exactly one `idx_valid` pulse, one clock later. No pulse appears without a step. A load in the same cycle as a step takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture the shape word and start position |
| cfg_word | input | CFG_W | Shape configuration word |
| start_pos | input | POS_W | Element position to resume from |
| step | input | 1 | Produce the next remapped index |
| idx_valid | output | 1 | `idx` holds a new remapped index |
| idx | output | 3*DIM_W | Remapped element index |
| cfg_err | output | 1 | Loaded order select is illegal |

## Verification
The scoreboard runs full passes over a flat 3x2 array with forward order and with swapped order, so a wrong carry chain or a wrong field position shows up as a different sequence. Three-dimensional shapes are run under several order selects and reverse masks, which separates stride errors from nesting errors and separates size-minus-one reversal from size reversal. Shapes smaller than the step count show the wraparound, and a modulus smaller than the array size shows the reduction. Restarts at mid-sequence positions, and at positions past the array size, check the derivation of the counters. An all-zero shape word and an illegal order select cover the pass-through and the suppression of outputs.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;
   localparam int NAX = 3;

   // Packed slot table: bits [1:0] name the fastest axis, [5:4] the slowest.
   typedef logic [5:0] nest_t;

   function automatic nest_t nest_of(input logic [2:0] sel);
      case (sel)
         3'd1:    nest_of = {2'd1, 2'd2, 2'd0};
         3'd2:    nest_of = {2'd2, 2'd0, 2'd1};
         3'd3:    nest_of = {2'd0, 2'd2, 2'd1};
         3'd4:    nest_of = {2'd1, 2'd0, 2'd2};
         3'd5:    nest_of = {2'd0, 2'd1, 2'd2};
         default: nest_of = {2'd2, 2'd1, 2'd0};
      endcase
   endfunction
endpackage

// File: rtl/remap_axis_ctr.sv
module remap_axis_ctr #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic [CW-1:0] lim,
   input  logic          en,
   output logic [CW-1:0] cnt,
   output logic          at_max
);
   assign at_max = (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (en)     cnt <= at_max ? '0 : cnt + 1'b1;
   end

   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim);
   p_wrap_to_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && at_max && !load) |=> (cnt == '0));
endmodule

// File: rtl/remap_index_calc.sv
module remap_index_calc #(
   parameter int DIM_W  = 6,
   parameter int POS_W  = 12,
   parameter bit MOD_EN = 1'b1,
   localparam int IDX_W = 3 * DIM_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic               bypass,
   input  logic [POS_W-1:0]   pos,
   input  logic [3*DIM_W-1:0] cnt_all,
   input  logic [3*DIM_W-1:0] lim_all,
   input  logic [2:0]         rev,
   input  logic [DIM_W-1:0]   modv,
   output logic               idx_valid,
   output logic [IDX_W-1:0]   idx
);
   logic [IDX_W-1:0] ax [3];
   logic [IDX_W-1:0] lin, red;
   logic [IDX_W-1:0] xs, ys;

   for (genvar a = 0; a < 3; a++) begin : g_ax
      logic [DIM_W-1:0] c, l;
      assign c = cnt_all[a*DIM_W +: DIM_W];
      assign l = lim_all[a*DIM_W +: DIM_W];
      assign ax[a] = IDX_W'(rev[a] ? (l - c) : c);
   end

   assign xs  = IDX_W'(lim_all[DIM_W-1:0]) + 1'b1;
   assign ys  = IDX_W'(lim_all[2*DIM_W-1:DIM_W]) + 1'b1;
   assign lin = ax[0] + ax[1] * xs + ax[2] * xs * ys;

   if (MOD_EN) begin : g_mod
      assign red = (modv != '0) ? (lin % IDX_W'(modv)) : lin;
      p_idx_below_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (idx_valid && $past(modv) != '0 && !$past(bypass)) |-> (idx < IDX_W'($past(modv))));
   end else begin : g_nomod
      assign red = lin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_valid <= 1'b0;
         idx       <= '0;
      end else begin
         idx_valid <= fire;
         if (fire) idx <= bypass ? IDX_W'(pos) : red;
      end
   end
endmodule

// File: rtl/idx_remap_seq.sv
module idx_remap_seq #(
   parameter int CFG_W  = 32,
   parameter int DIM_W  = 6,
   parameter int POS_W  = 12,
   parameter bit MOD_EN = 1'b1,
   localparam int IDX_W = 3 * DIM_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_load,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [POS_W-1:0] start_pos,
   input  logic             step,
   output logic             idx_valid,
   output logic [IDX_W-1:0] idx,
   output logic             cfg_err
);
   import idx_remap_pkg::*;

   localparam int SEL_LSB  = 3 * DIM_W;
   localparam int REV_LSB  = SEL_LSB + 3;
   localparam int MOD_LSB  = REV_LSB + 3;
   localparam int CFG_USED = MOD_LSB + DIM_W;
   localparam int TOT_W    = 3 * (DIM_W + 1);
   localparam int AW       = (POS_W > TOT_W) ? POS_W : TOT_W;

   if (CFG_USED > CFG_W) begin : g_bad_cfg_w
      $error("shape fields do not fit in CFG_W");
   end
   if (DIM_W < 1 || POS_W < 1) begin : g_bad_w
      $error("DIM_W and POS_W must be positive");
   end

   // ---------------- decode of the incoming word (used at load) ----------------
   logic [2:0]    in_sel;
   logic          in_bad;
   nest_t         in_nest;
   logic [AW-1:0] sz [3];
   logic [AW-1:0] tot, kk, q0, c0, c1, c2;
   logic [DIM_W-1:0] seed [3];

   assign in_sel  = cfg_word[SEL_LSB +: 3];
   assign in_bad  = (in_sel > 3'd5);
   assign in_nest = nest_of(in_bad ? 3'd0 : in_sel);

   for (genvar a = 0; a < 3; a++) begin : g_sz
      assign sz[a] = AW'(cfg_word[a*DIM_W +: DIM_W]) + 1'b1;
   end

   always_comb begin
      logic [AW-1:0] l0, l1;
      l0  = sz[in_nest[1:0]];
      l1  = sz[in_nest[3:2]];
      tot = sz[0] * sz[1] * sz[2];
      kk  = AW'(start_pos) % tot;
      c0  = kk % l0;
      q0  = kk / l0;
      c1  = q0 % l1;
      c2  = q0 / l1;
      for (int a = 0; a < 3; a++) begin
         if (in_nest[1:0] == 2'(a))      seed[a] = DIM_W'(c0);
         else if (in_nest[3:2] == 2'(a)) seed[a] = DIM_W'(c1);
         else                            seed[a] = DIM_W'(c2);
      end
   end

   // ---------------- captured shape ----------------
   logic [3*DIM_W-1:0] lim_q;
   nest_t              nest_q;
   logic [2:0]         rev_q;
   logic [DIM_W-1:0]   mod_q;
   logic               off_q, err_q;
   logic [POS_W-1:0]   pos_q;
   logic               adv;

   assign adv     = step && !cfg_load && !err_q;
   assign cfg_err = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_q  <= '0;
         nest_q <= nest_of(3'd0);
         rev_q  <= '0;
         mod_q  <= '0;
         off_q  <= 1'b1;
         err_q  <= 1'b0;
         pos_q  <= '0;
      end else if (cfg_load) begin
         lim_q  <= cfg_word[3*DIM_W-1:0];
         nest_q <= in_nest;
         rev_q  <= cfg_word[REV_LSB +: 3];
         mod_q  <= cfg_word[MOD_LSB +: DIM_W];
         off_q  <= (cfg_word == '0);
         err_q  <= in_bad;
         pos_q  <= start_pos;
      end else if (adv) begin
         pos_q  <= pos_q + 1'b1;
      end
   end

   // ---------------- axis counters and carry chain ----------------
   logic [3*DIM_W-1:0] cnt_all;
   logic [2:0]         at_max;
   logic [3:0]         at_max_x;
   logic [2:0]         en;

   assign at_max_x = {1'b0, at_max};

   always_comb begin
      for (int a = 0; a < 3; a++) begin
         if (nest_q[1:0] == 2'(a))      en[a] = adv;
         else if (nest_q[3:2] == 2'(a)) en[a] = adv && at_max_x[nest_q[1:0]];
         else                           en[a] = adv && at_max_x[nest_q[1:0]] && at_max_x[nest_q[3:2]];
      end
   end

   for (genvar a = 0; a < NAX; a++) begin : g_axis
      remap_axis_ctr #(.CW(DIM_W)) u_ctr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (cfg_load),
         .load_val (seed[a]),
         .lim      (lim_q[a*DIM_W +: DIM_W]),
         .en       (en[a]),
         .cnt      (cnt_all[a*DIM_W +: DIM_W]),
         .at_max   (at_max[a])
      );
   end

   remap_index_calc #(.DIM_W(DIM_W), .POS_W(POS_W), .MOD_EN(MOD_EN)) u_calc (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (adv),
      .bypass    (off_q),
      .pos       (pos_q),
      .cnt_all   (cnt_all),
      .lim_all   (lim_q),
      .rev       (rev_q),
      .modv      (mod_q),
      .idx_valid (idx_valid),
      .idx       (idx)
   );

   p_err_blocks_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cfg_err) |=> !idx_valid);
   p_valid_needs_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> $past(step && !cfg_load));
   p_step_gives_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cfg_load && !cfg_err) |=> idx_valid);
   p_fast_axis_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !off_q) |-> $onehot(en | 3'b000) || (en[nest_q[1:0]] == 1'b1));
endmodule

// File: tb/idx_remap_seq_test.sv
`timescale 1ns/1ps
module idx_remap_seq_test;
   localparam int CFG_W = 32, DIM_W = 6, POS_W = 12, IDX_W = 3 * DIM_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_load = 1'b0;
   logic [CFG_W-1:0] cfg_word = '0;
   logic [POS_W-1:0] start_pos = '0;
   logic             step = 1'b0;
   logic             idx_valid;
   logic [IDX_W-1:0] idx;
   logic             cfg_err;

   int errors = 0, checks = 0;
   bit done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #2 clk = ~clk;

   idx_remap_seq #(.CFG_W(CFG_W), .DIM_W(DIM_W), .POS_W(POS_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .start_pos(start_pos), .step(step), .idx_valid(idx_valid), .idx(idx),
      .cfg_err(cfg_err));

   function automatic logic [31:0] mk(int xs, int ys, int zs, int sel, int rev, int m);
      return {2'b00, 6'(m), 3'(rev), 3'(sel), 6'(zs), 6'(ys), 6'(xs)};
   endfunction

   // Expected index taken from the requirements (R2..R9).
   function automatic int model(logic [31:0] c, int n);
      int l[3], o[3], cc[3], v, k, tot, m;
      if (c == 0) return n % (1 << POS_W);
      l[0] = c[5:0] + 1; l[1] = c[11:6] + 1; l[2] = c[17:12] + 1;
      case (c[20:18])
         3'd1: o = '{0, 2, 1};
         3'd2: o = '{1, 0, 2};
         3'd3: o = '{1, 2, 0};
         3'd4: o = '{2, 0, 1};
         3'd5: o = '{2, 1, 0};
         default: o = '{0, 1, 2};
      endcase
      tot = l[0] * l[1] * l[2];
      k = n % tot;
      cc[o[0]] = k % l[o[0]]; k = k / l[o[0]];
      cc[o[1]] = k % l[o[1]]; cc[o[2]] = k / l[o[1]];
      for (int a = 0; a < 3; a++) if (c[21 + a]) cc[a] = l[a] - 1 - cc[a];
      v = cc[0] + cc[1] * l[0] + cc[2] * l[0] * l[1];
      m = c[29:24];
      if (m != 0) v = v % m;
      return v;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Monitor: pops the scoreboard for every valid index.
   always @(negedge clk) begin
      if (rst_n && !done && idx_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R11 unexpected valid", int'(idx), -1);
         else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(int'(idx) == e, t, int'(idx), e);
         end
      end
   end

   task automatic run(input logic [31:0] c, input int start, input int n, input string tag);
      @(negedge clk);
      cfg_load = 1'b1; cfg_word = c; start_pos = POS_W'(start);
      @(negedge clk);
      cfg_load = 1'b0;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model(c, start + i));
         tag_q.push_back(tag);
         step = 1'b1;
         @(negedge clk);
      end
      step = 1'b0;
      @(negedge clk);
      check(idx_valid == 1'b0, "R11 idle no valid", int'(idx_valid), 0);
      check(exp_q.size() == 0, "R11 one result per step", exp_q.size(), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(idx_valid == 1'b0, "R1 valid low", int'(idx_valid), 0);
      check(cfg_err == 1'b0, "R1 err low", int'(cfg_err), 0);
      check(idx == '0, "R1 idx zero", int'(idx), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run(mk(2, 1, 0, 0, 0, 0), 0, 6, "R2 biased sizes 3x2");
      run(mk(1, 2, 1, 0, 0, 0), 0, 12, "R4 3D strides");
      run(mk(2, 1, 0, 2, 0, 0), 0, 6, "R5 y fastest transpose");
      run(mk(1, 2, 1, 1, 0, 0), 0, 12, "R5 order x-z-y");
      run(mk(1, 2, 1, 3, 0, 0), 0, 12, "R5 order y-z-x");
      run(mk(1, 2, 1, 4, 0, 0), 0, 12, "R5 order z-x-y");
      run(mk(1, 2, 1, 5, 0, 0), 0, 12, "R5 order z-y-x");
      run(mk(1, 2, 1, 0, 5, 0), 0, 12, "R6 reverse x and z");
      run(mk(2, 1, 0, 2, 2, 0), 0, 6, "R6 reverse y");
      run(mk(3, 3, 0, 2, 0, 5), 0, 16, "R7 modulus 5");
      run(mk(1, 1, 0, 0, 0, 0), 0, 10, "R8 wrap repeat");
      run(mk(1, 2, 1, 3, 2, 0), 7, 10, "R9 restart mid");
      run(mk(1, 2, 1, 4, 1, 0), 30, 8, "R9 restart past size");
      run(32'h0, 100, 5, "R3 disabled passthrough");

      // R10: illegal order select
      @(negedge clk);
      cfg_load = 1'b1; cfg_word = mk(1, 1, 0, 7, 0, 0); start_pos = '0;
      @(negedge clk);
      cfg_load = 1'b0;
      check(cfg_err == 1'b1, "R10 err raised", int'(cfg_err), 1);
      step = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(idx_valid == 1'b0, "R10 valid suppressed", int'(idx_valid), 0);
      end
      step = 1'b0;
      run(mk(1, 1, 0, 0, 0, 0), 0, 2, "R10 recovery legal");
      check(cfg_err == 1'b0, "R10 err cleared", int'(cfg_err), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule